// File: doc/BRIEF.md
# Unsigned Double-Width by Single-Width Divider

This block divides an unsigned 16-bit dividend by an unsigned 8-bit divisor over several clock cycles. It delivers an 8-bit quotient and an 8-bit remainder in one 16-bit result word. Next to the result it gives two flags and an overflow indication. The flags describe the divisor: negative means divisor bit 7 is set, and zero means the divisor is zero. Neither flag describes the quotient.

A caller holds the operands and pulses `start` while `busy` is low. The divider runs a restoring algorithm that yields one quotient bit per clock. When the quotient cannot fit in 8 bits (the divisor is not greater than the dividend's upper byte), the iterations are skipped and the overflow output is raised. The result word, flags and overflow stay at their values until the next accepted start.

Top module: `udiv16by8`

## Requirements
- R1: When the divisor is greater than the dividend's upper byte, result bits [7:0] hold floor(dividend / divisor) and bits [15:8] hold dividend mod divisor.
- R2: `ovf` is 1 exactly when the divisor is less than or equal to dividend bits [15:8]; otherwise it is 0.
- R3: A zero divisor raises `ovf` and leaves the result word equal to the dividend.
- R4: `neg` equals bit 7 of the divisor of the accepted operation.
- R5: `zero` is 1 when the divisor of the accepted operation is zero and 0 otherwise.
- R6: Without overflow, `done` is high for exactly one cycle. That cycle directly follows the eighth iteration edge, i.e. it lies between the 8th and 9th rising edges after the edge that accepted `start`.
- R7: With overflow, `done` is high for one cycle directly after the accepting edge.
- R8: `busy` is high from the accepting edge through the `done` cycle. A `start` seen while `busy` is high is ignored and does not change the running operation's result.
- R9: While reset is applied, `busy`, `done`, `ovf`, `neg`, `zero` and `result` are all 0.
- R10: With `start` low and no operation running, `result`, `ovf`, `neg` and `zero` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins a division when idle |
| dividend | input | 16 | Unsigned dividend, sampled on the accepting edge |
| divisor | input | 8 | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Remainder in [15:8], quotient in [7:0] |
| ovf | output | 1 | Quotient does not fit in 8 bits |
| neg | output | 1 | Divisor bit 7 |
| zero | output | 1 | Divisor equals zero |

## Verification
The assertions assume that `start` is sampled only when its level is stable at the clock edge. They also assume that operands are meaningful only on the accepting edge. The partial-remainder invariant relies on every iterated operation having been screened for overflow on that edge. The stimulus drives `start` and the operands on falling edges only. It changes the operands freely while an operation runs or while the block is idle, which exercises the ignored-start and hold behaviour inside those assumptions. The sweep covers every divisor value and, for each, dividends whose upper byte sits on both sides of the overflow boundary.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } udiv_state_e;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ovf_now,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (QW > 1) ? $clog2(QW) : 1;
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  udiv_state_e state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_en  = 1'b1;
          cnt_n   = '0;
          state_n = ovf_now ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (cnt_q == LAST) begin
          state_n = ST_FIN;
        end else begin
          cnt_en = 1'b1;
          cnt_n  = cnt_q + 1'b1;
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != LAST) |=> (busy && !done));
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
  parameter int QW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [2*QW-1:0] dvd_in,
  input  logic [QW-1:0]   dvs_in,
  output logic [2*QW-1:0] result
);
  localparam int DW = 2 * QW;

  logic [QW-1:0] rem_q, rem_n;
  logic [QW-1:0] quo_q, quo_n;
  logic [QW-1:0] dvs_q;
  logic [QW:0]   partial;
  logic [QW:0]   trial;
  logic          fits;
  logic          upd_en;

  assign partial = {rem_q, quo_q[QW-1]};
  assign trial   = partial - {1'b0, dvs_q};
  assign fits    = ~trial[QW];

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    upd_en = 1'b0;
    if (load) begin
      upd_en = 1'b1;
      rem_n  = dvd_in[DW-1:QW];
      quo_n  = dvd_in[QW-1:0];
    end else if (step) begin
      upd_en = 1'b1;
      rem_n  = fits ? trial[QW-1:0] : partial[QW-1:0];
      quo_n  = {quo_q[QW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      if (upd_en) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
      end
      if (load) dvs_q <= dvs_in;
    end
  end

  assign result = {rem_q, quo_q};

  // R1: restoring invariant, partial remainder stays below divisor
  // R1
  rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < dvs_q));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(result));
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags #(
  parameter int QW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [2*QW-1:0] dvd_in,
  input  logic [QW-1:0]   dvs_in,
  output logic            ovf_now,
  output logic            ovf,
  output logic            neg,
  output logic            zero
);
  localparam int DW = 2 * QW;

  logic ovf_q, neg_q, zero_q;

  assign ovf_now = (dvs_in <= dvd_in[DW-1:QW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (load) begin
      ovf_q  <= ovf_now;
      neg_q  <= dvs_in[QW-1];
      zero_q <= (dvs_in == '0);
    end
  end

  assign ovf  = ovf_q;
  assign neg  = neg_q;
  assign zero = zero_q;

  // R3
  zero_forces_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> ovf);
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ovf) && $stable(neg) && $stable(zero)));
endmodule

// File: rtl/udiv16by8.sv
module udiv16by8 #(
  parameter int QW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic [2*QW-1:0] result,
  output logic            ovf,
  output logic            neg,
  output logic            zero
);
  localparam int DW = 2 * QW;

  logic rst_meta_q, rst_sync_q;
  logic load, step, ovf_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  udiv_ctrl #(.QW(QW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .start  (start),
    .ovf_now(ovf_now),
    .load   (load),
    .step   (step),
    .busy   (busy),
    .done   (done)
  );

  udiv_datapath #(.QW(QW)) u_dp (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (load),
    .step  (step),
    .dvd_in(dividend),
    .dvs_in(divisor),
    .result(result)
  );

  udiv_flags #(.QW(QW)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load   (load),
    .dvd_in (dividend),
    .dvs_in (divisor),
    .ovf_now(ovf_now),
    .ovf    (ovf),
    .neg    (neg),
    .zero   (zero)
  );

  // R7
  ovf_fast_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (start && !busy && (divisor <= dividend[DW-1:QW])) |=> (done && ovf));
  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (start && !busy) |=> busy);
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (!busy && !done && result == '0));
endmodule

// File: tb/tb_udiv16by8.sv
module tb_udiv16by8;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] dividend;
  logic [7:0]  divisor;
  logic        busy, done, ovf, neg, zero;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  udiv16by8 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .result(result),
    .ovf(ovf), .neg(neg), .zero(zero)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [7:0] b);
    logic exp_ovf;
    int   lat;
    exp_ovf = (b <= a[15:8]);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = ~a;
    lat = 1;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (exp_ovf) chk(lat == 1, "R7 ovf latency", lat, 1);
    else         chk(lat == 9, "R6 latency", lat, 9);
    chk(ovf == exp_ovf, "R2 ovf", ovf, exp_ovf);
    chk(neg == b[7], "R4 neg", neg, b[7]);
    chk(zero == (b == 0), "R5 zero", zero, (b == 0));
    if (!exp_ovf)
      chk(result == {8'(a % b), 8'(a / b)}, "R1 result", result,
          {8'(a % b), 8'(a / b)});
    if (b == 0)
      chk(result == a && ovf, "R3 zero divisor", result, a);
    @(negedge clk);
    chk(!done && !busy, "R6 done single pulse", {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] hold_r;
    logic        hold_o, hold_n, hold_z;
    rst_n = 1'b0; start = 1'b0; dividend = 16'h0; divisor = 8'h0;
    repeat (3) @(negedge clk);
    // R9
    chk(!busy && !done && !ovf && !neg && !zero && result == 0,
        "R9 reset state", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    lfsr = 16'hACE1;
    for (int d = 0; d < 256; d++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] a;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (j)
          0: a = {8'(d), lfsr[7:0]};
          1: a = {8'(d - 1), lfsr[7:0]};
          2: a = {8'h00, lfsr[7:0]};
          3: a = 16'hFFFF;
          4: a = 16'h0000;
          5: a = {8'(d - 1), 8'hFF};
          default: a = lfsr;
        endcase
        run_op(a, 8'(d));
      end
    end

    // R8: a start during a running operation is ignored
    @(negedge clk);
    dividend = 16'h1234; divisor = 8'h9A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 16'h0010; divisor = 8'h03; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(result == {8'(16'h1234 % 8'h9A), 8'(16'h1234 / 8'h9A)},
        "R8 start ignored while busy", result,
        {8'(16'h1234 % 8'h9A), 8'(16'h1234 / 8'h9A)});
    @(negedge clk);
    chk(!busy && !done, "R8 no second run", {busy, done}, 0);

    // R10: idle outputs hold while operand inputs move
    hold_r = result; hold_o = ovf; hold_n = neg; hold_z = zero;
    for (int k = 0; k < 6; k++) begin
      dividend = 16'(k * 16'h1357); divisor = 8'(k * 37);
      @(negedge clk);
    end
    chk(result == hold_r && ovf == hold_o && neg == hold_n && zero == hold_z,
        "R10 hold while idle", result, hold_r);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule